// File: doc/BRIEF.md
# Multi-Mode GPIO Port Controller

This block drives the pads of five 8-bit general-purpose I/O ports for a small 8-bit microcontroller. Each of the 40 pins has its own drive mode: quasi-bidirectional, push-pull, open-drain or input-only. For every pin the block produces four pad-control signals: output enable, output value, weak pull-up enable and a strong pull-up pulse. It returns the pad level to the core through an input-enable gate.

Software sets the port latches and the two mode bits of each pin through a simple write port. The reset mode of a pin depends on its port and on a tristate configuration fuse. In power-down the block switches off the input buffers, except on a fixed set of wake-up pins and on port 1 pins enabled for keyboard interrupt. A buffer that is switched off reads as 1, so a floating pad cannot cause a spurious read or a spurious wake-up.

Top module: `gpio_multimode_port`

## Requirements
- R1: A write with `wr_en` high addresses port `wr_addr[4:2]` and register `wr_addr[1:0]`: 0 is the latch, 1 the low mode bits, 2 the high mode bits. Pin `n` of the port takes mode `{high[n], low[n]}`, with 00 quasi-bidirectional, 01 push-pull, 10 input-only and 11 open-drain. Pad index is port*8 + bit. The write takes effect at the clock edge where `wr_en` is sampled.
- R2: At reset, all pins of ports 1, 2 and 3 and port 4 bits 2, 3, 6 and 7 take input-only mode when `fuse_tri` is 1 and quasi-bidirectional mode when it is 0.
- R3: At reset, port 0 pins and port 4 bits 0 and 1 take open-drain mode whatever the fuse, and port 4 bits 4 and 5 take quasi-bidirectional mode.
- R4: After reset every port latch holds 0xFF, and `pad_spu` is all zero.
- R5: `pad_out` equals the latch bit in every mode. In quasi-bidirectional mode a latch of 0 gives `pad_oe`=1 and `pad_wpu`=0, and a latch of 1 gives `pad_oe`=0 and `pad_wpu`=1.
- R6: In quasi-bidirectional mode, a latch change from 0 to 1 raises `pad_spu` for exactly PULSE_CYCLES (default 2) cycles, starting in the cycle after the write edge. A write that returns the latch to 0 ends the pulse in the next cycle. No pulse occurs in any other mode.
- R7: In push-pull mode `pad_oe` is 1, and `pad_wpu` and `pad_spu` are 0.
- R8: In open-drain mode `pad_oe` is the inverse of the latch. In input-only mode `pad_oe` is 0. In both modes `pad_wpu` and `pad_spu` are 0.
- R9: With `pwr_down` low, every `pad_ie` bit is 1 and `pin_val` equals `pad_in`.
- R10: With `pwr_down` high, `pad_ie` is 1 only on port 3 bits 2 and 3, on port 4 bits 6 and 7, and on port 1 bits whose `kbd_en` bit is 1. It is 0 on every other pin.
- R11: A pin whose `pad_ie` is 0 reads 1 on `pin_val`, whatever its pad level.
- R12: A write to a port index above 4, or to register select 3, changes no latch and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_tri | input | 1 | Tristate fuse; picks the fuse-dependent reset mode |
| pwr_down | input | 1 | Power-down; gates the input buffers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Port index in [4:2], register select in [1:0] |
| wr_data | input | 8 | Write data, one bit per pin |
| kbd_en | input | 8 | Keyboard-interrupt enable for each port 1 pin |
| pad_in | input | 40 | Pad input levels |
| pad_oe | output | 40 | Output driver enable |
| pad_out | output | 40 | Output value |
| pad_wpu | output | 40 | Weak pull-up enable |
| pad_spu | output | 40 | Strong pull-up pulse |
| pad_ie | output | 40 | Input buffer enable |
| pin_val | output | 40 | Gated pin value seen by the core |

## Verification
Two things can happen in the same window: the strong pull-up pulse of a pin, and a new latch write that clears that pin. The bench issues a 0-to-1 write and follows it with a write of 0 on the next clock edge. It expects `pad_spu` to drop in the cycle right after the second write, and it expects no pulse when the same rising write is made in push-pull mode. Power-down gating and a change of `kbd_en` are also checked while the latches hold mixed values. Each pin's `pad_ie` and `pin_val` are then compared with an enable vector that the bench computes from the port and bit numbers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NPORTS   = 5;
    localparam int PW       = 8;
    localparam int NPIN     = NPORTS * PW;
    localparam int KBD_PORT = 1;

    typedef enum logic [1:0] {
        MD_QUASI  = 2'b00,
        MD_PUSH   = 2'b01,
        MD_INPUT  = 2'b10,
        MD_ODRAIN = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_MODE0 = 2'd1,
        SEL_MODE1 = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic dout;
        logic wpu;
        logic spu;
    } pad_ctl_t;

    // Mode a pin takes at reset, from its port, its bit and the fuse
    function automatic pin_mode_e reset_mode(input int port, input int bitn, input logic fuse);
        pin_mode_e m;
        if (port == 0)
            m = MD_ODRAIN;
        else if (port == 4 && bitn < 2)
            m = MD_ODRAIN;
        else if (port == 4 && (bitn == 4 || bitn == 5))
            m = MD_QUASI;
        else
            m = fuse ? MD_INPUT : MD_QUASI;
        return m;
    endfunction

    // Pins whose input buffer stays on in power-down
    function automatic logic wake_exempt(input int port, input int bitn);
        return (port == 3 && (bitn == 2 || bitn == 3)) ||
               (port == 4 && (bitn == 6 || bitn == 7));
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fuse_tri,
    input  logic                  wr_en,
    input  logic [4:0]            wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NPIN-1:0]       latch_q,
    output logic [NPIN-1:0][1:0]  mode_q
);

    logic [2:0] wr_port;
    reg_sel_e   wr_sel;

    assign wr_port = wr_addr[4:2];
    assign wr_sel  = reg_sel_e'(wr_addr[1:0]);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic                 hit;
        logic [PW-1:0]        lat;
        logic [PW-1:0][1:0]   md;

        assign hit = wr_en && (wr_port == 3'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                lat <= '1;
                for (int b = 0; b < PW; b++)
                    md[b] <= reset_mode(p, b, fuse_tri);
            end else if (hit) begin
                case (wr_sel)
                    SEL_LATCH: lat <= wr_data;
                    SEL_MODE0: for (int b = 0; b < PW; b++) md[b][0] <= wr_data[b];
                    SEL_MODE1: for (int b = 0; b < PW; b++) md[b][1] <= wr_data[b];
                    default:   ;
                endcase
            end
        end

        assign latch_q[p*PW +: PW] = lat;
        assign mode_q[p*PW +: PW]  = md;
    end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_port_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       latch,
    input  logic [1:0] mode,
    output pad_ctl_t   ctl
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);

    pin_mode_e      md;
    logic           prev;
    logic           rise;
    logic           quasi;
    logic [CW-1:0]  cnt;

    assign md    = pin_mode_e'(mode);
    assign quasi = (md == MD_QUASI);
    assign rise  = latch & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            cnt  <= '0;
        end else begin
            prev <= latch;
            if (!latch || !quasi)
                cnt <= '0;
            else if (rise)
                cnt <= CW'(PULSE_CYCLES - 1);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        ctl.dout = latch;
        ctl.wpu  = 1'b0;
        ctl.spu  = 1'b0;
        unique case (md)
            MD_QUASI: begin
                ctl.oe  = ~latch;
                ctl.wpu = latch;
                ctl.spu = latch & (rise | (cnt != '0));
            end
            MD_PUSH:   ctl.oe = 1'b1;
            MD_INPUT:  ctl.oe = 1'b0;
            MD_ODRAIN: ctl.oe = ~latch;
            default:   ctl.oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_in_gate.sv
module gpio_in_gate
    import gpio_port_pkg::*;
(
    input  logic            pwr_down,
    input  logic [PW-1:0]   kbd_en,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_ie,
    output logic [NPIN-1:0] pin_val
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam int PORT = i / PW;
        localparam int BITN = i % PW;
        if (wake_exempt(PORT, BITN)) begin : g_wake
            assign pad_ie[i] = 1'b1;
        end else if (PORT == KBD_PORT) begin : g_kbd
            assign pad_ie[i] = ~pwr_down | kbd_en[BITN];
        end else begin : g_plain
            assign pad_ie[i] = ~pwr_down;
        end
        assign pin_val[i] = pad_ie[i] ? pad_in[i] : 1'b1;
    end

endmodule

// File: rtl/gpio_multimode_port.sv
module gpio_multimode_port
    import gpio_port_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fuse_tri,
    input  logic            pwr_down,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      kbd_en,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_wpu,
    output logic [NPIN-1:0] pad_spu,
    output logic [NPIN-1:0] pad_ie,
    output logic [NPIN-1:0] pin_val
);

    logic [NPIN-1:0]      latch_q;
    logic [NPIN-1:0][1:0] mode_q;

    gpio_port_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .fuse_tri (fuse_tri),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .latch_q  (latch_q),
        .mode_q   (mode_q)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_drv
        pad_ctl_t ctl;
        gpio_pin_drive #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
            .clk   (clk),
            .rst   (rst),
            .latch (latch_q[i]),
            .mode  (mode_q[i]),
            .ctl   (ctl)
        );
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.dout;
        assign pad_wpu[i] = ctl.wpu;
        assign pad_spu[i] = ctl.spu;
    end

    gpio_in_gate u_gate (
        .pwr_down (pwr_down),
        .kbd_en   (kbd_en),
        .pad_in   (pad_in),
        .pad_ie   (pad_ie),
        .pin_val  (pin_val)
    );

endmodule

// File: rtl/gpio_multimode_port_chk.sv
module gpio_multimode_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            fuse_tri,
    input logic            pwr_down,
    input logic            wr_en,
    input logic [4:0]      wr_addr,
    input logic [7:0]      wr_data,
    input logic [7:0]      kbd_en,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_wpu,
    input logic [NPIN-1:0] pad_spu,
    input logic [NPIN-1:0] pad_ie,
    input logic [NPIN-1:0] pin_val
);

    // R9
    awake_ie_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |-> (&pad_ie));

    // R10
    wake_pins_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (pad_ie[26] && pad_ie[27] && pad_ie[38] && pad_ie[39]));

    // R10
    kbd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> ((kbd_en & ~pad_ie[15:8]) == 8'h00));

    // R11
    gated_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((~pad_ie & ~pin_val) == '0));

    // R9
    pass_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_ie & (pin_val ^ pad_in)) == '0));

    // R5
    spu_quasi_high_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_spu & (~pad_out | pad_oe | ~pad_wpu)) == '0));

    for (genvar i = 0; i < NPIN; i++) begin : g_pulse
        logic [15:0] run;
        always_ff @(posedge clk) begin
            if (rst)
                run <= '0;
            else if (pad_spu[i])
                run <= (run == 16'hFFFF) ? run : run + 16'd1;
            else
                run <= '0;
        end

        // R6
        spu_max_len_chk: assert property (@(posedge clk) disable iff (rst)
            pad_spu[i] |-> (run < 16'(PULSE_CYCLES)));

        // R6
        spu_full_len_chk: assert property (@(posedge clk) disable iff (rst)
            ($fell(pad_spu[i]) && pad_wpu[i]) |-> (run == 16'(PULSE_CYCLES)));

        // R6
        spu_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pad_spu[i]) |-> $rose(pad_out[i]));
    end

endmodule

bind gpio_multimode_port gpio_multimode_port_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (.*);

// File: tb/gpio_multimode_port_tb_top.sv
`timescale 1ns/1ps
module gpio_multimode_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fuse_tri = 1'b0;
    logic        pwr_down = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  kbd_en = '0;
    logic [39:0] pad_in = '0;
    logic [39:0] pad_oe, pad_out, pad_wpu, pad_spu, pad_ie, pin_val;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] m_lat  [5];
    logic [1:0] m_mode [5][8];

    always #2.5 clk = ~clk;

    gpio_multimode_port #(.PULSE_CYCLES(2)) dut_i (
        .clk(clk), .rst(rst), .fuse_tri(fuse_tri), .pwr_down(pwr_down),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .kbd_en(kbd_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_wpu(pad_wpu),
        .pad_spu(pad_spu), .pad_ie(pad_ie), .pin_val(pin_val)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_reset_mode(input int p, input int b, input logic f);
        if (p == 0 || (p == 4 && b <= 1)) return 2'b11;
        if (p == 4 && (b == 4 || b == 5)) return 2'b00;
        return f ? 2'b10 : 2'b00;
    endfunction

    task automatic check_pads(input string tag);
        logic [39:0] eoe, eout, ewpu;
        for (int p = 0; p < 5; p++)
            for (int b = 0; b < 8; b++) begin
                logic l;
                l = m_lat[p][b];
                eout[p*8+b] = l;
                ewpu[p*8+b] = (m_mode[p][b] == 2'b00) && l;
                case (m_mode[p][b])
                    2'b01:   eoe[p*8+b] = 1'b1;
                    2'b10:   eoe[p*8+b] = 1'b0;
                    default: eoe[p*8+b] = ~l;
                endcase
            end
        check({tag, " oe"},  pad_oe,  eoe);
        check({tag, " out"}, pad_out, eout);
        check({tag, " wpu"}, pad_wpu, ewpu);
        check({tag, " spu"}, pad_spu, 40'h0);
    endtask

    task automatic do_reset(input logic f);
        @(negedge clk);
        rst = 1'b1;
        fuse_tri = f;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 5; p++) begin
            m_lat[p] = 8'hFF;
            for (int b = 0; b < 8; b++) m_mode[p][b] = exp_reset_mode(p, b, f);
        end
    endtask

    // returns at the falling edge right after the write edge
    task automatic wr(input int port, input int sel, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = {3'(port), 2'(sel)};
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (port < 5) begin
            for (int b = 0; b < 8; b++) begin
                if (sel == 0) m_lat[port][b] = d[b];
                if (sel == 1) m_mode[port][b][0] = d[b];
                if (sel == 2) m_mode[port][b][1] = d[b];
            end
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pd_check(input string tag);
        logic [39:0] eie, ev;
        #1;
        for (int p = 0; p < 5; p++)
            for (int b = 0; b < 8; b++) begin
                logic on;
                on = !pwr_down ||
                     (p == 3 && (b == 2 || b == 3)) ||
                     (p == 4 && b >= 6) ||
                     (p == 1 && kbd_en[b]);
                eie[p*8+b] = on;
                ev[p*8+b]  = on ? pad_in[p*8+b] : 1'b1;
            end
        check({tag, " ie"}, pad_ie, eie);
        check({tag, " val"}, pin_val, ev);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        logic [39:0] s_oe, s_out, s_wpu;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

        // R2 R3 R4: reset modes for both fuse values
        for (int f = 0; f < 2; f++) begin
            do_reset(1'(f));
            check_pads($sformatf("R4 R2 R3 reset fuse=%0d", f));
            for (int p = 0; p < 5; p++) wr(p, 0, 8'h00);
            settle();
            check_pads($sformatf("R2 R3 reset-mode probe fuse=%0d", f));
        end

        // R1 R5 R7 R8: uniform modes, several latch patterns
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 5; p++) begin
                wr(p, 1, m[0] ? 8'hFF : 8'h00);
                wr(p, 2, m[1] ? 8'hFF : 8'h00);
            end
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 5; p++) wr(p, 0, pats[k] ^ 8'(p));
                settle();
                check_pads($sformatf("R1 R5 R7 R8 mode=%0d pat=%0d", m, k));
            end
        end

        // R1: mixed modes within a port
        for (int p = 0; p < 5; p++) begin
            wr(p, 1, 8'h55 ^ 8'(p));
            wr(p, 2, 8'h33 << (p % 3));
        end
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 5; p++) wr(p, 0, pats[k] + 8'(p * 17));
            settle();
            check_pads($sformatf("R1 mixed pat=%0d", k));
        end

        // R6: pulse length in quasi mode
        for (int p = 0; p < 5; p++) begin wr(p, 1, 8'h00); wr(p, 2, 8'h00); wr(p, 0, 8'h00); end
        settle();
        wr(2, 0, 8'h81);
        check("R6 pulse cycle1", pad_spu, 40'h00_00_81_00_00);
        @(negedge clk);
        check("R6 pulse cycle2", pad_spu, 40'h00_00_81_00_00);
        @(negedge clk);
        check("R6 pulse ended", pad_spu, 40'h0);
        check("R6 weak pull-up held", pad_wpu, 40'h00_00_81_00_00);

        // R6: pulse cut short by a write of 0 on the next edge
        wr(1, 0, 8'hFF);
        check("R6 cut pulse start", pad_spu, 40'h00_00_00_FF_00);
        wr(1, 0, 8'h00);
        check("R6 cut pulse end", pad_spu, 40'h0);

        // R6 R7: no pulse in push-pull mode
        wr(0, 1, 8'hFF);
        wr(0, 0, 8'h00);
        settle();
        wr(0, 0, 8'hFF);
        check("R6 R7 no pulse push-pull", pad_spu, 40'h0);
        settle();
        check_pads("R7 push-pull settled");

        // R12: writes that must be ignored
        s_oe = pad_oe; s_out = pad_out; s_wpu = pad_wpu;
        for (int p = 5; p < 8; p++)
            for (int s = 0; s < 4; s++) wr(p, s, 8'h5A);
        for (int p = 0; p < 5; p++) wr(p, 3, 8'h5A);
        settle();
        check("R12 ignored oe", pad_oe, s_oe);
        check("R12 ignored out", pad_out, s_out);
        check("R12 ignored wpu", pad_wpu, s_wpu);

        // R9 R10 R11: input gating
        pad_in = 40'hA5_3C_0F_96_5A;
        pwr_down = 1'b0;
        pd_check("R9 awake");
        pad_in = 40'h0;
        pwr_down = 1'b1;
        kbd_en = 8'h00;
        pd_check("R10 R11 pd no kbd zeros");
        for (int b = 0; b < 8; b++) begin
            kbd_en = 8'(1 << b);
            pd_check($sformatf("R10 R11 pd kbd bit %0d", b));
        end
        kbd_en = 8'hFF;
        pd_check("R10 pd kbd all");
        pad_in = 40'hA5_3C_0F_96_5A;
        kbd_en = 8'h5A;
        pd_check("R10 R11 pd kbd 5A pattern");
        pad_in = '1;
        kbd_en = 8'h81;
        pd_check("R11 pd ones");
        pwr_down = 1'b0;
        pad_in = 40'h12_34_56_78_9A;
        pd_check("R9 wake again");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule